// File: doc/BRIEF.md
# Byte Read-Modify-Write Sequencer

This block carries out the byte-sized memory forms of the logic instructions: test, and, exclusive-or, or, and test-and-set. The decoder hands it one instruction word together with the current values of R0, the global base register and the general register named in the word. The block works out the byte address, reads the byte over a simple byte bus, combines it with the 8-bit immediate, and, except for the test form, writes the result back to the same address. When the sequence ends it raises a one-cycle done pulse and, for the forms that produce a T flag, the new flag value with a write enable.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the sequencer is idle. The decoder holds `cmd_valid` and the command fields steady until it sees `cmd_ready`, and the command is taken on the rising edge where both are high. Nothing is queued, so a new command waits until the previous sequence has finished. The memory side uses one strobe per phase. The strobe and the address stay where they are until the memory answers with `mem_ready` in the same cycle.

The block also arbitrates its memory bus against two other requesters. An external bus-release request is granted in every cycle. An internal DMA request may take the bus between the sequencer's phases. During a test-and-set, `bus_lock` is high from the cycle after the read up to and including the write, and DMA is held off for that whole span.

Top module: `byte_rmw_seq`

## Requirements
- R1: `cmd_ready` is high exactly when no sequence is running, and a command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high.
- R2: Instruction words 0xCDii (and), 0xCEii (exclusive-or) and 0xCFii (or) read the byte, apply the operation with immediate ii, and write the result to the same address. With zero wait states, done is high in the third cycle after the command is taken.
- R3: Word 0xCCii (test) reads the byte and produces T = 1 when (byte AND ii) is zero, otherwise T = 0. It never asserts `mem_wr`. With zero wait states, done and `t_we` are high in the third cycle after the command is taken.
- R4: A word matching binary 0100 nnnn 0001 1011 (test-and-set) reads the byte at the address carried on `cmd_rn`. It produces T = 1 when the byte is zero, otherwise T = 0, and it writes the byte back with bit 7 set. With zero wait states, done is high in the fourth cycle after the command is taken.
- R5: For the 0xCC to 0xCF forms, the address is `cmd_r0 + cmd_gbr`, and the sum wraps modulo 2^32.
- R6: A read or write phase stays in place, with the strobe high whenever the bus is granted to the sequencer and the address held steady, until `mem_ready` is high. Each wait cycle adds one cycle to the sequence.
- R7: During a test-and-set, `bus_lock` is high from the cycle after the read through the write cycle, and `dma_gnt` stays low in that span even when `dma_req` is high.
- R8: `ext_gnt` follows `ext_req` in every cycle. While `ext_req` is high the sequencer drives no strobe and its phase is stalled.
- R9: Outside the lock span, a high `dma_req` is granted and the pending sequencer phase stalls with its strobe low.
- R10: Any other instruction word is accepted and then dropped. It causes no strobe and no done, and `cmd_ready` is high again in the next cycle.
- R11: After reset, `cmd_ready` is high, `mem_rd`, `mem_wr`, `done`, `t_we`, `bus_lock` are low, and `t_val` is 0.
- R12: `done` is high for exactly one cycle per accepted sequence. `t_we` is high only together with `done`, and only for the test and test-and-set forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_insn | input | 16 | Instruction word |
| cmd_r0 | input | AW | Value of R0 |
| cmd_gbr | input | AW | Value of the global base register |
| cmd_rn | input | AW | Value of the register named in the word |
| mem_addr | output | AW | Byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Phase completes this cycle |
| dma_req | input | 1 | Internal DMA wants the bus |
| dma_gnt | output | 1 | Bus granted to internal DMA |
| ext_req | input | 1 | External bus-release request |
| ext_gnt | output | 1 | Bus released to external requester |
| bus_lock | output | 1 | Read-to-write window of test-and-set is open |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| t_we | output | 1 | T flag update strobe |
| t_val | output | 1 | New T flag value |

## Verification
The hardest situation to reach from the ports is a competing request that arrives inside the lock window. A DMA request raised before the read would simply win the read phase, so the bench raises `dma_req` only after the read has completed. It then checks that `dma_gnt` stays low for the rest of the span and becomes high once the window closes. A second directed case holds `ext_req` across the write cycle of a test-and-set, to show that the external requester still gets the bus and that the write slides later. Wait states are produced by a memory model whose ready latency is set for each vector.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TST,
    OP_AND,
    OP_XOR,
    OP_OR,
    OP_TAS
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_EXE,
    S_EXE2,
    S_WR,
    S_TFL
  } state_e;

  function automatic logic [BYTE_W-1:0] rmw_apply(
    input op_e               op,
    input logic [BYTE_W-1:0] rd,
    input logic [BYTE_W-1:0] imm
  );
    case (op)
      OP_AND:  return rd & imm;
      OP_XOR:  return rd ^ imm;
      OP_OR:   return rd | imm;
      OP_TAS:  return rd | {1'b1, {(BYTE_W-1){1'b0}}};
      default: return rd;
    endcase
  endfunction

  function automatic logic rmw_tzero(
    input op_e               op,
    input logic [BYTE_W-1:0] rd,
    input logic [BYTE_W-1:0] imm
  );
    if (op == OP_TAS) return (rd == '0);
    return ((rd & imm) == '0);
  endfunction

  function automatic logic op_sets_t(input op_e op);
    return (op == OP_TST) || (op == OP_TAS);
  endfunction

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [15:0]       insn,
  input  logic [AW-1:0]     r0,
  input  logic [AW-1:0]     gbr,
  input  logic [AW-1:0]     rn,
  output op_e               op,
  output logic [BYTE_W-1:0] imm,
  output logic [AW-1:0]     addr
);

  always_comb begin
    casez (insn)
      16'b11001100_????????: op = OP_TST;
      16'b11001101_????????: op = OP_AND;
      16'b11001110_????????: op = OP_XOR;
      16'b11001111_????????: op = OP_OR;
      16'b0100????_00011011: op = OP_TAS;
      default:               op = OP_NONE;
    endcase
  end

  assign imm  = insn[BYTE_W-1:0];
  // the sum is truncated to AW bits, giving wrap-around (R5)
  assign addr = (op == OP_TAS) ? rn : (r0 + gbr);

endmodule

// File: rtl/rmw_bus_arb.sv
module rmw_bus_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic want_bus,
  input  logic lock,
  input  logic dma_req,
  input  logic ext_req,
  output logic dma_gnt,
  output logic ext_gnt,
  output logic own_gnt
);

  // priority: external release, then DMA (unless locked), then sequencer
  assign ext_gnt = ext_req;
  assign dma_gnt = dma_req && !ext_req && !lock;
  assign own_gnt = want_bus && !ext_req && !(dma_req && !lock);

  p_lock_nodma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && dma_req) |-> !dma_gnt);

  p_ext_honor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (ext_gnt && !own_gnt));

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({own_gnt, dma_gnt, ext_gnt}));

endmodule

// File: rtl/byte_rmw_seq.sv
module byte_rmw_seq
  import rmw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_insn,
  input  logic [AW-1:0]     cmd_r0,
  input  logic [AW-1:0]     cmd_gbr,
  input  logic [AW-1:0]     cmd_rn,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ready,
  input  logic              dma_req,
  output logic              dma_gnt,
  input  logic              ext_req,
  output logic              ext_gnt,
  output logic              bus_lock,
  output logic              done,
  output logic              t_we,
  output logic              t_val
);

  state_e            st_q, st_d;
  op_e               op_q;
  logic [BYTE_W-1:0] imm_q, rbuf_q, wbuf_q;
  logic [AW-1:0]     addr_q;
  logic              t_q;

  op_e               dec_op;
  logic [BYTE_W-1:0] dec_imm;
  logic [AW-1:0]     dec_addr;

  rmw_decode #(.AW(AW)) u_dec (
    .insn (cmd_insn),
    .r0   (cmd_r0),
    .gbr  (cmd_gbr),
    .rn   (cmd_rn),
    .op   (dec_op),
    .imm  (dec_imm),
    .addr (dec_addr)
  );

  logic want_bus, own_gnt, lock, phase_ok, accept;

  assign want_bus = (st_q == S_RD) || (st_q == S_WR);
  assign lock     = (op_q == OP_TAS) && (st_q inside {S_EXE, S_EXE2, S_WR});

  rmw_bus_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_bus (want_bus),
    .lock     (lock),
    .dma_req  (dma_req),
    .ext_req  (ext_req),
    .dma_gnt  (dma_gnt),
    .ext_gnt  (ext_gnt),
    .own_gnt  (own_gnt)
  );

  assign cmd_ready = (st_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign mem_rd    = own_gnt && (st_q == S_RD);
  assign mem_wr    = own_gnt && (st_q == S_WR);
  assign phase_ok  = own_gnt && mem_ready;
  assign mem_addr  = addr_q;
  assign mem_wdata = wbuf_q;
  assign bus_lock  = lock;
  assign done      = ((st_q == S_WR) && phase_ok) || (st_q == S_TFL);
  assign t_we      = done && op_sets_t(op_q);
  assign t_val     = t_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (accept && dec_op != OP_NONE) st_d = S_RD;
      S_RD:   if (phase_ok) st_d = S_EXE;
      S_EXE: begin
        if (op_q == OP_TST)      st_d = S_TFL;
        else if (op_q == OP_TAS) st_d = S_EXE2;
        else                     st_d = S_WR;
      end
      S_EXE2: st_d = S_WR;
      S_WR:   if (phase_ok) st_d = S_IDLE;
      S_TFL:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_NONE;
      imm_q  <= '0;
      rbuf_q <= '0;
      wbuf_q <= '0;
      addr_q <= '0;
      t_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q   <= dec_op;
        imm_q  <= dec_imm;
        addr_q <= dec_addr;
      end
      if ((st_q == S_RD) && phase_ok) rbuf_q <= mem_rdata;
      if (st_q == S_EXE) begin
        wbuf_q <= rmw_apply(op_q, rbuf_q, imm_q);
        if (op_sets_t(op_q)) t_q <= rmw_tzero(op_q, rbuf_q, imm_q);
      end
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_rd && !mem_wr && !done));

  p_tst_nowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_TST && st_q != S_IDLE) |-> !mem_wr);

  p_tas_bit7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && op_q == OP_TAS) |-> mem_wdata[BYTE_W-1]);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ready) |=> $stable(mem_addr));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_twe_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    t_we |-> done);

endmodule

// File: tb/tb_byte_rmw_seq.sv
module tb_byte_rmw_seq;

  localparam int AW = 32;
  localparam int VW = 171;
  localparam int NV = 10;

  // {insn, r0, gbr, rn, rbyte, lat, exp_cycles, exp_wr, exp_wdata, exp_addr, exp_twe, exp_t}
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'hCD0F, 32'h0000_0010, 32'h1000_0000, 32'h0, 8'h3C, 4'd0, 4'd3, 1'b1, 8'h0C, 32'h1000_0010, 1'b0, 1'b0},
    {16'hCFA0, 32'h0000_0004, 32'h2000_0000, 32'h0, 8'h05, 4'd0, 4'd3, 1'b1, 8'hA5, 32'h2000_0004, 1'b0, 1'b0},
    {16'hCEFF, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0, 8'h5A, 4'd0, 4'd3, 1'b1, 8'hA5, 32'h0000_0001, 1'b0, 1'b0},
    {16'hCC81, 32'h0000_0008, 32'h0000_0100, 32'h0, 8'h7E, 4'd0, 4'd3, 1'b0, 8'h00, 32'h0000_0108, 1'b1, 1'b1},
    {16'hCC81, 32'h0000_0008, 32'h0000_0100, 32'h0, 8'h80, 4'd0, 4'd3, 1'b0, 8'h00, 32'h0000_0108, 1'b1, 1'b0},
    {16'h451B, 32'h0000_0011, 32'h0000_0022, 32'h0000_4000, 8'h00, 4'd0, 4'd4, 1'b1, 8'h80, 32'h0000_4000, 1'b1, 1'b1},
    {16'h4F1B, 32'h0, 32'h0, 32'hABCD_0001, 8'h41, 4'd0, 4'd4, 1'b1, 8'hC1, 32'hABCD_0001, 1'b1, 1'b0},
    {16'hCD0F, 32'h0, 32'h0000_0030, 32'h0, 8'hFF, 4'd2, 4'd7, 1'b1, 8'h0F, 32'h0000_0030, 1'b0, 1'b0},
    {16'hCC01, 32'h0000_0001, 32'h0000_0001, 32'h0, 8'h01, 4'd3, 4'd6, 1'b0, 8'h00, 32'h0000_0002, 1'b1, 1'b0},
    {16'h401B, 32'h0, 32'h0, 32'h0000_0010, 8'h80, 4'd1, 4'd6, 1'b1, 8'h80, 32'h0000_0010, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [15:0]   cmd_insn = '0;
  logic [AW-1:0] cmd_r0 = '0, cmd_gbr = '0, cmd_rn = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, mem_ready;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = '0;
  logic          dma_req = 1'b0, ext_req = 1'b0;
  logic          dma_gnt, ext_gnt, bus_lock, done, t_we, t_val;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  int wr_count = 0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [7:0]    wr_data = '0;

  always #2.5 clk = ~clk;

  byte_rmw_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_insn(cmd_insn),
    .cmd_r0(cmd_r0), .cmd_gbr(cmd_gbr), .cmd_rn(cmd_rn),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .dma_req(dma_req), .dma_gnt(dma_gnt), .ext_req(ext_req), .ext_gnt(ext_gnt),
    .bus_lock(bus_lock), .done(done), .t_we(t_we), .t_val(t_val)
  );

  // memory model with programmable ready latency
  assign mem_ready = (mem_rd || mem_wr) && (wcnt >= lat);

  always @(posedge clk) begin
    if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_rd && mem_ready) rd_addr <= mem_addr;
    if (mem_wr && mem_ready) begin
      wr_count <= wr_count + 1;
      wr_addr  <= mem_addr;
      wr_data  <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] insn, input logic [31:0] r0,
                       input logic [31:0] gbr, input logic [31:0] rn);
    @(negedge clk);
    cmd_insn = insn; cmd_r0 = r0; cmd_gbr = gbr; cmd_rn = rn;
    cmd_valid = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] f_insn;
    logic [31:0] f_r0, f_gbr, f_rn, f_addr;
    logic [7:0]  f_rb, f_wd;
    logic [3:0]  f_lat, f_cyc;
    logic        f_wr, f_tw, f_t;
    int          cyc, wr0;
    logic        tw, tv;
    string       rq;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 cmd_ready", cmd_ready, 1);
    chk("R11 strobes", {mem_rd, mem_wr}, 0);
    chk("R11 done/t_we/lock", {done, t_we, bus_lock}, 0);
    chk("R11 t_val", t_val, 0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      {f_insn, f_r0, f_gbr, f_rn, f_rb, f_lat, f_cyc, f_wr, f_wd, f_addr, f_tw, f_t} = VEC[i];
      rq = (f_insn[15:12] == 4'h4) ? "R4" : (f_insn[15:8] == 8'hCC) ? "R3" : "R2";
      if (f_lat != 0) rq = {rq, "/R6"};
      lat = int'(f_lat);
      mem_rdata = f_rb;
      wr0 = wr_count;
      cyc = 0; tw = 1'b0; tv = 1'b0;
      issue(f_insn, f_r0, f_gbr, f_rn);
      for (int c = 1; c <= 20; c++) begin
        @(negedge clk);
        if (c == 1) cmd_valid = 1'b0;
        #1;
        if (c == 1) chk("R1 busy cmd_ready", cmd_ready, 0);
        if (done) begin
          cyc = c; tw = t_we; tv = t_val;
          break;
        end
      end
      @(posedge clk); #1;
      chk({rq, " cycles"}, cyc, f_cyc);
      chk({rq, "/R5 read addr"}, rd_addr, f_addr);
      chk({rq, " write count"}, wr_count - wr0, f_wr);
      if (f_wr) begin
        chk({rq, " write addr"}, wr_addr, f_addr);
        chk({rq, " write data"}, wr_data, f_wd);
      end
      chk({rq, "/R12 t_we"}, tw, f_tw);
      if (f_tw) chk({rq, " T value"}, tv, f_t);
    end
    lat = 0;

    // R10: unsupported word is dropped
    wr0 = wr_count;
    issue(16'h2009, 32'h1, 32'h2, 32'h3);
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (c == 1) cmd_valid = 1'b0;
      #1;
      chk("R10 ready", cmd_ready, 1);
      chk("R10 no strobe/done", {mem_rd, mem_wr, done}, 0);
    end

    // R9: DMA preempts the read phase of an and
    mem_rdata = 8'hF0;
    wr0 = wr_count; cyc = 0;
    issue(16'hCD3C, 32'h0, 32'h40, 32'h0);
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c == 1) begin cmd_valid = 1'b0; dma_req = 1'b1; end
      if (c == 3) dma_req = 1'b0;
      #1;
      if (c <= 2) begin
        chk("R9 dma_gnt", dma_gnt, 1);
        chk("R9 read stalled", mem_rd, 0);
      end
      if (done) begin cyc = c; break; end
    end
    @(posedge clk); #1;
    chk("R9 cycles", cyc, 5);
    chk("R9 write data", wr_data, 8'h30);

    // R7: DMA held off inside the test-and-set window
    mem_rdata = 8'h00;
    cyc = 0;
    issue(16'h431B, 32'h0, 32'h0, 32'h0000_0500);
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c == 1) cmd_valid = 1'b0;
      if (c == 2) dma_req = 1'b1;
      #1;
      if (c >= 2 && c <= 4) begin
        chk("R7 dma_gnt low", dma_gnt, 0);
        chk("R7 bus_lock", bus_lock, 1);
      end
      if (done) begin cyc = c; break; end
    end
    chk("R7 cycles", cyc, 4);
    @(negedge clk); #1;
    chk("R7 dma_gnt after window", dma_gnt, 1);
    chk("R7 lock released", bus_lock, 0);
    dma_req = 1'b0;

    // R8: external request still granted inside the window
    mem_rdata = 8'h01;
    cyc = 0;
    issue(16'h471B, 32'h0, 32'h0, 32'h0000_0600);
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c == 1) cmd_valid = 1'b0;
      if (c == 3) ext_req = 1'b1;
      if (c == 6) ext_req = 1'b0;
      #1;
      if (c >= 3 && c <= 5) chk("R8 ext_gnt", ext_gnt, 1);
      if (c == 4 || c == 5) chk("R8 write stalled", {mem_wr, bus_lock}, 2'b01);
      if (done) begin cyc = c; tv = t_val; break; end
    end
    @(posedge clk); #1;
    chk("R8 cycles", cyc, 6);
    chk("R8/R4 write data", wr_data, 8'h81);
    chk("R4 T nonzero", tv, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule